// File: doc/BRIEF.md
# Multi-Input Edge Wake-Up Unit

The unit watches eight external input lines. Each line is first passed through a synchronizer, then through an edge detector whose direction software chooses. A detected edge sets a sticky pending bit for that line. The pending bits, gated by per-line enable bits, are merged into one interrupt for the processor. The same merged condition is also driven out as a wake-up request that tells the power controller to leave halt, idle or power-save mode.

The whole unit runs on one clock. That clock must be the free-running slow clock, so detection keeps working while the fast clock is stopped. Software reaches the unit through a small register port: a single-cycle write strobe with an address and data, and a read address whose data comes back registered one cycle later.

When a line's polarity is changed, its pending bit is cleared, so the change of direction cannot leave a stale event behind. When a hardware edge and a software clear hit the same bit in the same cycle, the edge wins, so no event is lost.

Top module: `edge_wake_unit`

## Requirements
- R1: After reset, the enable, polarity and pending registers all read 0, and `irq_o` and `wake_o` are 0.
- R2: Polarity bit 1 selects the rising edge and polarity bit 0 selects the falling edge. A transition in the selected direction on `pin_i[n]` sets pending bit n within five clock cycles. A transition in the other direction leaves pending bit n unchanged.
- R3: A pending bit stays set until software writes 1 to that bit position of the pending register (address 2). A write of 0 to a bit position leaves that bit unchanged.
- R4: `irq_o` is 1, one cycle after the registers change, exactly when some channel has both its pending bit and its enable bit (address 0) set.
- R5: `wake_o` follows the same condition as `irq_o` in the same cycle.
- R6: A disabled channel still records edges in its pending bit, but it does not raise `irq_o`. Enabling the channel later raises `irq_o` when its pending bit is already set.
- R7: A write to the polarity register (address 1) clears the pending bit of every channel whose polarity bit changes value.
- R8: When an edge sets a pending bit in the same cycle that a clear write targets that same bit, the bit ends up set.
- R9: `rdata_o` returns, one cycle after `rd_addr_i` is presented, the register selected: address 0 is enable, address 1 is polarity, address 2 is pending, and address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running slow clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NCH | Asynchronous external input lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | NCH | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rdata_o | output | NCH | Registered read data |
| irq_o | output | 1 | Combined interrupt to the processor |
| wake_o | output | 1 | Wake-up request to the power controller |

## Verification
The assertions assume that `pin_i` is held steady for several cycles between changes, so that every edge passes through the synchronizer as one clean transition. They also assume that a pending bit changes only through an edge event, a clear write or a polarity change. The stimulus meets both assumptions: it drives each line on the falling clock edge and waits at least five cycles before the next change. Register writes last exactly one cycle. The single collision case lines up a write with an edge to the exact cycle in which the edge is detected.

// File: rtl/ewu_pkg.sv
package ewu_pkg;
  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_POLAR  = 2'd1,
    REG_PEND   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ewu_sync.sv
module ewu_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ewu_edge_det.sv
module ewu_edge_det #(
  parameter int NCH    = 8,
  parameter int SETTLE = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] lvl_i,
  input  logic [NCH-1:0] pol_i,
  output logic [NCH-1:0] evt_o
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [NCH-1:0] prev_q;
  logic [CW-1:0]  arm_cnt_q;
  logic           armed;

  assign armed = (arm_cnt_q == CW'(SETTLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      arm_cnt_q <= '0;
    end else begin
      prev_q <= lvl_i;
      if (!armed) arm_cnt_q <= arm_cnt_q + 1'b1;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic rise, fall;
    assign rise     = lvl_i[n] & ~prev_q[n];
    assign fall     = ~lvl_i[n] & prev_q[n];
    assign evt_o[n] = armed & (pol_i[n] ? rise : fall);
  end

  // R2: an event on a channel needs its level to have moved since the last cycle
  a_r2_evt_needs_change: assert property (@(posedge clk) disable iff (rst)
    ((evt_o & ~(lvl_i ^ prev_q)) == '0));
endmodule

// File: rtl/ewu_regs.sv
module ewu_regs
  import ewu_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_addr_i,
  input  logic [NCH-1:0] wr_data_i,
  input  logic [1:0]     rd_addr_i,
  input  logic [NCH-1:0] evt_i,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] pol_o,
  output logic [NCH-1:0] pend_o,
  output logic [NCH-1:0] rdata_o
);
  logic [NCH-1:0] en_q, pol_q, pend_q, rdata_q;
  logic [NCH-1:0] w1c_mask, pol_chg_mask, pend_nxt;
  logic           wr_en_sel, wr_pol_sel, wr_pend_sel;

  assign wr_en_sel   = wr_en_i && (wr_addr_i == REG_ENABLE);
  assign wr_pol_sel  = wr_en_i && (wr_addr_i == REG_POLAR);
  assign wr_pend_sel = wr_en_i && (wr_addr_i == REG_PEND);

  assign w1c_mask     = wr_pend_sel ? wr_data_i : '0;
  assign pol_chg_mask = wr_pol_sel ? (wr_data_i ^ pol_q) : '0;

  always_comb begin
    // event wins over a clear write, polarity change wins over both
    pend_nxt = ((pend_q & ~w1c_mask) | evt_i) & ~pol_chg_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      pol_q   <= '0;
      pend_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en_sel)  en_q  <= wr_data_i;
      if (wr_pol_sel) pol_q <= wr_data_i;
      pend_q <= pend_nxt;
      case (reg_sel_e'(rd_addr_i))
        REG_ENABLE: rdata_q <= en_q;
        REG_POLAR:  rdata_q <= pol_q;
        REG_PEND:   rdata_q <= pend_q;
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign pend_o  = pend_q;
  assign rdata_o = rdata_q;

  // R3: a pending bit drops only through a clear write or a polarity change
  a_r3_sticky_pend: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~$past(pend_q) | $past(w1c_mask) | $past(pol_chg_mask) | pend_q) == '1));
  // R2: a pending bit rises only when the edge detector reported an event
  a_r2_set_by_event: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt_i)) == '0));
  // R7: a changed polarity bit leaves its pending bit cleared
  a_r7_pol_clears: assert property (@(posedge clk) disable iff (rst)
    wr_pol_sel |=> ((pend_q & $past(wr_data_i ^ pol_q)) == '0));
  // R8: an event beats a same-cycle clear on the same bit
  a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_pend_sel && ((evt_i & wr_data_i) != '0) && !wr_pol_sel)
      |=> ((pend_q & $past(evt_i & wr_data_i)) == $past(evt_i & wr_data_i)));
endmodule

// File: rtl/edge_wake_unit.sv
module edge_wake_unit #(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pin_i,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_addr_i,
  input  logic [NCH-1:0] wr_data_i,
  input  logic [1:0]     rd_addr_i,
  output logic [NCH-1:0] rdata_o,
  output logic           irq_o,
  output logic           wake_o
);
  localparam int SETTLE = SYNC_STAGES + 1;

  logic [NCH-1:0] lvl, evt, en, pol, pend;
  logic           irq_q, wake_q;

  ewu_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(lvl)
  );

  ewu_edge_det #(.NCH(NCH), .SETTLE(SETTLE)) u_edge (
    .clk(clk), .rst(rst), .lvl_i(lvl), .pol_i(pol), .evt_o(evt)
  );

  ewu_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .evt_i(evt),
    .en_o(en), .pol_o(pol), .pend_o(pend), .rdata_o(rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= |(pend & en);
      wake_q <= |(pend & en);
    end
  end

  assign irq_o  = irq_q;
  assign wake_o = wake_q;

  // R1: outputs are low in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_o && !wake_o));
  // R4: a rising interrupt needs an enabled pending channel the cycle before
  a_r4_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(pend & en) != '0));
  // R5: the wake request tracks the interrupt
  a_r5_wake_tracks: assert property (@(posedge clk) disable iff (rst)
    wake_o == irq_o);
endmodule

// File: tb/sim_edge_wake_unit.sv
module sim_edge_wake_unit;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] pin_i = '0;
  logic           wr_en_i = 1'b0;
  logic [1:0]     wr_addr_i = '0;
  logic [NCH-1:0] wr_data_i = '0;
  logic [1:0]     rd_addr_i = '0;
  logic [NCH-1:0] rdata_o;
  logic           irq_o, wake_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_wake_unit #(.NCH(NCH), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .pin_i(pin_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [NCH-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [NCH-1:0] d);
    @(negedge clk);
    rd_addr_i = a;
    @(negedge clk);
    d = rdata_o;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [NCH-1:0] v, en_v, pol_v, exp_p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle(5);
    // R1 reset state
    rd(2'd0, v); check("R1 enable", v, 0);
    rd(2'd1, v); check("R1 polarity", v, 0);
    rd(2'd2, v); check("R1 pending", v, 0);
    check("R1 irq", irq_o, 0);
    check("R1 wake", wake_o, 0);

    // R2/R4/R5 sweep: every channel, both polarities
    for (int ch = 0; ch < NCH; ch++) begin
      for (int p = 0; p < 2; p++) begin
        en_v  = (ch % 2 == 1) ? NCH'(1) << ch : '1;
        pol_v = (p == 1) ? NCH'(1) << ch : '0;
        wr(2'd0, en_v);
        wr(2'd1, pol_v);
        wr(2'd2, '1);
        settle(2);
        pin_i[ch] = 1'b1;
        settle(6);
        exp_p = (p == 1) ? NCH'(1) << ch : '0;
        rd(2'd2, v); check("R2 rising", v, exp_p);
        check("R4 irq rising", irq_o, |(exp_p & en_v));
        check("R5 wake rising", wake_o, |(exp_p & en_v));
        wr(2'd2, '1);
        settle(2);
        pin_i[ch] = 1'b0;
        settle(6);
        exp_p = (p == 0) ? NCH'(1) << ch : '0;
        rd(2'd2, v); check("R2 falling", v, exp_p);
        check("R4 irq falling", irq_o, |(exp_p & en_v));
        wr(2'd2, '1);
        settle(3);
        check("R3 cleared", irq_o, 0);
      end
    end

    // R3: write 0 leaves bits, write 1 clears only its bit
    wr(2'd1, 8'h03);
    pin_i = 8'h03;
    settle(6);
    wr(2'd2, 8'h00);
    rd(2'd2, v); check("R3 zero write", v, 8'h03);
    wr(2'd2, 8'h01);
    rd(2'd2, v); check("R3 one write", v, 8'h02);

    // R6: disabled channel records but no irq
    wr(2'd0, 8'h00);
    settle(3);
    check("R6 no irq disabled", irq_o, 0);
    wr(2'd0, 8'h02);
    settle(2);
    check("R6 irq after enable", irq_o, 1);

    // R7: polarity change on ch1 clears its pending bit
    wr(2'd1, 8'h01);
    settle(2);
    rd(2'd2, v); check("R7 pol change clears", v, 8'h00);
    settle(2);
    check("R7 irq drops", irq_o, 0);

    // R8: edge on ch2 (rising) meets a clear write in its detection cycle
    pin_i = 8'h00;
    wr(2'd1, 8'h04);
    settle(6);
    wr(2'd2, '1);
    @(negedge clk);
    pin_i[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 2'd2; wr_data_i = 8'h04;
    @(negedge clk);
    wr_en_i = 1'b0;
    rd(2'd2, v); check("R8 event wins", v, 8'h04);

    // R9 register map
    wr(2'd0, 8'hA5);
    rd(2'd0, v); check("R9 enable readback", v, 8'hA5);
    rd(2'd1, v); check("R9 polarity readback", v, 8'h04);
    rd(2'd3, v); check("R9 spare zero", v, 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule